// File: doc/BRIEF.md
# Effective Address and Clock Estimator

This block takes one decoded instruction descriptor per cycle and produces two results. The first is the 16-bit effective address of the memory operand. It is built from a base register value, an index register value and an optional displacement, as the addressing mode selects. The second is an estimate of the clock cost of the instruction. That estimate covers simple move and add forms.

The cost has three parts:
- a fixed base cost for the operation form;
- an address-calculation cost that depends on the addressing mode;
- a bus-transfer penalty.

The penalty applies to word transfers at an odd address on a 16-bit external bus, and to every word transfer on an 8-bit external bus. A running total of all estimated clocks is kept from reset.

The block is a performance-model stage. A decoder feeds it through a valid/ready input. The per-instruction clock count and the updated total appear one cycle after acceptance, qualified by an output valid flag. Fetch, decoding, segment arithmetic and the memory access itself belong to other blocks.

Top module: `ea_clock_estimator`

## Requirements
- R1: `ea_o` is the sum, modulo 2^16, of the terms that `mode_i` selects.
  - Direct (0) takes the displacement only.
  - Base (1) takes base plus displacement.
  - Index (2) takes index plus displacement.
  - Fast pair (3) and slow pair (4) take base plus index plus displacement.
  - In modes 1 to 4 the displacement is zero when `disp_en_i` is 0.
  - When `disp8_i` is 1 the displacement is `disp_i[7:0]` sign-extended; otherwise it is `disp_i`.
- R2: Address cost for single terms:
  - direct mode costs 6 clocks;
  - base-only or index-only without a displacement costs 5;
  - base-only or index-only with a displacement costs 9.
- R3: Address cost for register pairs:
  - the fast pair (base BP with index DI, or BX with SI) costs 7, or 11 with a displacement;
  - the slow pair (BP with SI, or BX with DI) costs 8, or 12 with a displacement.
- R4: Memory forms (`form_i`) have these base costs, to which the address cost is added:
  - 4: register from memory, move, 8;
  - 5: memory from register, move, 9;
  - 6: register from memory, add, 9;
  - 7: memory from register, add, 16;
  - 8: memory with immediate, add, 17.
- R5: Register-only forms cost a fixed amount, with no address cost and no penalty on either bus:
  - 0: move immediate, 4;
  - 1: move register, 2;
  - 2: add register, 3;
  - 3: add immediate, 4.
- R6: With `narrow_bus_i` = 0, a word operand (`word_i` = 1) at an odd `ea_o` adds 4 clocks per transfer. Forms 4 to 6 make one transfer. Forms 7 and 8 make two transfers and so add 8.
- R7: With `narrow_bus_i` = 1, every word transfer adds 4 clocks whatever the address parity: 4 for forms 4 to 6 and 8 for forms 7 and 8.
- R8: A byte operand (`word_i` = 0) never incurs a transfer penalty, on either bus or at any address.
- R9: `total_o` is 0 after reset. It grows by exactly the clock count of each accepted descriptor and does not change in cycles with no acceptance.
- R10: `in_ready_o` is high from the first cycle after reset. `out_valid_o`, `ea_o`, `clocks_o` and the new `total_o` appear in the cycle after acceptance, and `out_valid_o` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Descriptor valid |
| in_ready_o | output | 1 | Descriptor can be accepted |
| mode_i | input | 3 | Addressing mode: 0 direct, 1 base, 2 index, 3 fast pair, 4 slow pair |
| base_i | input | 16 | Base register value |
| index_i | input | 16 | Index register value |
| disp_i | input | 16 | Displacement, or direct address |
| disp_en_i | input | 1 | Displacement present (modes 1 to 4) |
| disp8_i | input | 1 | Displacement is 8-bit, sign-extended |
| form_i | input | 4 | Operation form code (R4, R5) |
| word_i | input | 1 | Word operand when 1, byte operand when 0 |
| narrow_bus_i | input | 1 | 8-bit external bus when 1 |
| out_valid_o | output | 1 | Result valid |
| ea_o | output | 16 | Effective address |
| clocks_o | output | 8 | Clocks for this instruction |
| total_o | output | 32 | Running clock total |

## Verification
Under a back-to-back stream, the total is updated with the previous descriptor's cost in the same cycle that the next descriptor is accepted. An error in accumulation or in holding the pipeline register therefore shows up as a wrong total on a later item. The bench drives runs of consecutive descriptors and runs separated by idle gaps. The scoreboard compares the address, the clock count and a bench-side running total on every valid output. After each gap it also checks at the ports that the total has not moved and that no result was produced.

// File: rtl/ea_est_pkg.sv
package ea_est_pkg;

  typedef enum logic [2:0] {
    AM_DIRECT    = 3'd0,
    AM_BASE      = 3'd1,
    AM_INDEX     = 3'd2,
    AM_PAIR_FAST = 3'd3,
    AM_PAIR_SLOW = 3'd4
  } am_e;

  typedef enum logic [3:0] {
    OP_MOV_RI = 4'd0,
    OP_MOV_RR = 4'd1,
    OP_ADD_RR = 4'd2,
    OP_ADD_RI = 4'd3,
    OP_MOV_RM = 4'd4,
    OP_MOV_MR = 4'd5,
    OP_ADD_RM = 4'd6,
    OP_ADD_MR = 4'd7,
    OP_ADD_MI = 4'd8
  } op_e;

  localparam int unsigned XFER_PENALTY = 4;

endpackage

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
  import ea_est_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic [2:0]    mode_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] index_i,
  input  logic [AW-1:0] disp_i,
  input  logic          disp_en_i,
  input  logic          disp8_i,
  output logic [AW-1:0] ea_o
);

  logic [AW-1:0] disp_ext;
  logic [AW-1:0] disp_term;
  logic [AW-1:0] base_term;
  logic [AW-1:0] index_term;

  assign disp_ext = disp8_i ? {{(AW-8){disp_i[7]}}, disp_i[7:0]} : disp_i;

  always_comb begin
    base_term  = '0;
    index_term = '0;
    disp_term  = disp_en_i ? disp_ext : '0;
    unique case (am_e'(mode_i))
      AM_BASE:      base_term  = base_i;
      AM_INDEX:     index_term = index_i;
      AM_PAIR_FAST,
      AM_PAIR_SLOW: begin
        base_term  = base_i;
        index_term = index_i;
      end
      default:      disp_term  = disp_ext;  // direct: displacement is the address
    endcase
  end

  assign ea_o = base_term + index_term + disp_term;

endmodule

// File: rtl/ea_cycle_lut.sv
module ea_cycle_lut
  import ea_est_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic [2:0]    mode_i,
  input  logic          disp_en_i,
  output logic [CW-1:0] ea_clk_o
);

  always_comb begin
    unique case (am_e'(mode_i))
      AM_BASE,
      AM_INDEX:     ea_clk_o = disp_en_i ? CW'(9)  : CW'(5);
      AM_PAIR_FAST: ea_clk_o = disp_en_i ? CW'(11) : CW'(7);
      AM_PAIR_SLOW: ea_clk_o = disp_en_i ? CW'(12) : CW'(8);
      default:      ea_clk_o = CW'(6);
    endcase
  end

endmodule

// File: rtl/op_cost.sv
module op_cost
  import ea_est_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic [3:0]    form_i,
  input  logic          word_i,
  input  logic          narrow_bus_i,
  input  logic          ea_lsb_i,
  input  logic [CW-1:0] ea_clk_i,
  output logic [CW-1:0] clk_o
);

  logic [CW-1:0] base_clk;
  logic [1:0]    xfers;
  logic [CW-1:0] pen_each;
  logic [CW-1:0] ea_part;

  always_comb begin
    xfers = 2'd0;
    unique case (op_e'(form_i))
      OP_MOV_RI: base_clk = CW'(4);
      OP_MOV_RR: base_clk = CW'(2);
      OP_ADD_RR: base_clk = CW'(3);
      OP_ADD_RI: base_clk = CW'(4);
      OP_MOV_RM: begin base_clk = CW'(8);  xfers = 2'd1; end
      OP_MOV_MR: begin base_clk = CW'(9);  xfers = 2'd1; end
      OP_ADD_RM: begin base_clk = CW'(9);  xfers = 2'd1; end
      OP_ADD_MR: begin base_clk = CW'(16); xfers = 2'd2; end
      OP_ADD_MI: begin base_clk = CW'(17); xfers = 2'd2; end
      default:   base_clk = CW'(2);
    endcase
  end

  // byte operands never pay; words pay on a narrow bus or an odd address
  assign pen_each = (word_i && (narrow_bus_i || ea_lsb_i)) ? CW'(XFER_PENALTY) : '0;
  assign ea_part  = (xfers != 2'd0) ? ea_clk_i : '0;
  assign clk_o    = base_clk + ea_part + (pen_each * CW'(xfers));

endmodule

// File: rtl/ea_clock_estimator.sv
module ea_clock_estimator
  import ea_est_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 8,
  parameter int unsigned TW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [2:0]    mode_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] index_i,
  input  logic [AW-1:0] disp_i,
  input  logic          disp_en_i,
  input  logic          disp8_i,
  input  logic [3:0]    form_i,
  input  logic          word_i,
  input  logic          narrow_bus_i,
  output logic          out_valid_o,
  output logic [AW-1:0] ea_o,
  output logic [CW-1:0] clocks_o,
  output logic [TW-1:0] total_o
);

  logic [AW-1:0] ea_d;
  logic [CW-1:0] ea_clk;
  logic [CW-1:0] clk_d;
  logic          accept;
  logic          ready_q;
  logic          vld_q;
  logic [AW-1:0] ea_q;
  logic [CW-1:0] clk_q;
  logic [TW-1:0] tot_q;

  ea_addr_gen #(.AW(AW)) u_addr (
    .mode_i   (mode_i),
    .base_i   (base_i),
    .index_i  (index_i),
    .disp_i   (disp_i),
    .disp_en_i(disp_en_i),
    .disp8_i  (disp8_i),
    .ea_o     (ea_d)
  );

  ea_cycle_lut #(.CW(CW)) u_lut (
    .mode_i   (mode_i),
    .disp_en_i(disp_en_i),
    .ea_clk_o (ea_clk)
  );

  op_cost #(.CW(CW)) u_cost (
    .form_i      (form_i),
    .word_i      (word_i),
    .narrow_bus_i(narrow_bus_i),
    .ea_lsb_i    (ea_d[0]),
    .ea_clk_i    (ea_clk),
    .clk_o       (clk_d)
  );

  assign accept = in_valid_i && ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      vld_q   <= 1'b0;
      ea_q    <= '0;
      clk_q   <= '0;
      tot_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      vld_q   <= accept;
      if (accept) begin
        ea_q  <= ea_d;
        clk_q <= clk_d;
        tot_q <= tot_q + TW'(clk_d);
      end
    end
  end

  assign in_ready_o  = ready_q;
  assign out_valid_o = vld_q;
  assign ea_o        = ea_q;
  assign clocks_o    = clk_q;
  assign total_o     = tot_q;

  // R9
  total_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> total_o == $past(total_o) + TW'(clocks_o));

  // R9
  total_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(total_o));

  // R10
  out_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  // R10
  no_spur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_ready_o) |=> !out_valid_o);

  // R4
  clk_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (clocks_o >= CW'(2) && clocks_o <= CW'(37)));

  // R5
  reg_form_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && form_i < 4'd4) |=> clocks_o <= CW'(4));

  // R8
  byte_nopen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && !word_i && form_i == 4'd7) |=> clocks_o <= CW'(28));

endmodule

// File: tb/ea_clock_estimator_tb.sv
module ea_clock_estimator_tb;

  typedef struct {
    logic [15:0] ea;
    logic [7:0]  clk;
    logic [31:0] tot;
    string       tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [2:0]  mode_i = '0;
  logic [15:0] base_i = '0;
  logic [15:0] index_i = '0;
  logic [15:0] disp_i = '0;
  logic        disp_en_i = 1'b0;
  logic        disp8_i = 1'b0;
  logic [3:0]  form_i = '0;
  logic        word_i = 1'b0;
  logic        narrow_bus_i = 1'b0;
  logic        out_valid_o;
  logic [15:0] ea_o;
  logic [7:0]  clocks_o;
  logic [31:0] total_o;

  int   n_chk = 0;
  int   n_fail = 0;
  int   run_tot = 0;
  exp_t sb[$];

  always #5 clk_i = ~clk_i;

  ea_clock_estimator u_dut (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .mode_i, .base_i, .index_i,
    .disp_i, .disp_en_i, .disp8_i, .form_i, .word_i, .narrow_bus_i,
    .out_valid_o, .ea_o, .clocks_o, .total_o
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic send(input int mode, input int base, input int idx, input int disp,
                      input bit den, input bit d8, input int form, input bit word,
                      input bit narrow, input int exp_ea, input int exp_clk,
                      input string tag);
    exp_t e;
    in_valid_i   = 1'b1;
    mode_i       = 3'(mode);
    base_i       = 16'(base);
    index_i      = 16'(idx);
    disp_i       = 16'(disp);
    disp_en_i    = den;
    disp8_i      = d8;
    form_i       = 4'(form);
    word_i       = word;
    narrow_bus_i = narrow;
    run_tot      = run_tot + exp_clk;
    e.ea  = 16'(exp_ea);
    e.clk = 8'(exp_clk);
    e.tot = 32'(run_tot);
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid_i = 1'b0;
      @(negedge clk_i);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (rst_ni && out_valid_o) begin
        if (sb.size() == 0) begin
          check(1'b0, "R10", "unexpected out_valid", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(ea_o == e.ea, e.tag, "ea", ea_o, e.ea);
          check(clocks_o == e.clk, e.tag, "clocks", clocks_o, e.clk);
          check(total_o == e.tot, "R9", {"total after ", e.tag}, total_o, e.tot);
        end
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    check(out_valid_o == 1'b0, "R10", "reset out_valid", out_valid_o, 0);
    check(total_o == 32'd0, "R9", "reset total", total_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    check(in_ready_o == 1'b1, "R10", "ready after reset", in_ready_o, 1);
    check(total_o == 32'd0, "R9", "total idle after reset", total_o, 0);
    @(negedge clk_i);

    // register forms
    send(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 4, "R5 mov r,imm");
    send(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 2, "R5 mov r,r");
    send(0, 0, 0, 0, 0, 0, 2, 1, 0, 0, 3, "R5 add r,r");
    send(0, 0, 0, 0, 0, 0, 3, 1, 0, 0, 4, "R5 add r,imm");
    // single-term modes
    send(0, 0, 0, 1000, 0, 0, 4, 1, 0, 1000, 14, "R2 direct");
    send(1, 1000, 0, 0, 0, 0, 4, 1, 0, 1000, 13, "R2 base");
    send(2, 0, 3000, 0, 0, 0, 5, 1, 0, 3000, 14, "R2 index");
    send(2, 0, 4000, 1000, 1, 0, 5, 1, 0, 5000, 18, "R2 index+disp");
    idle(3);
    #1;
    check(out_valid_o == 1'b0, "R10", "no output while idle", out_valid_o, 0);
    check(total_o == 32'(run_tot), "R9", "total held while idle", total_o, run_tot);
    @(negedge clk_i);
    // pairs
    send(3, 2000, 4000, 0, 0, 0, 4, 1, 0, 6000, 15, "R3 fast pair");
    send(4, 2000, 3000, 0, 0, 0, 4, 1, 0, 5000, 16, "R3 slow pair");
    send(3, 1000, 3000, 1000, 1, 0, 5, 1, 0, 5000, 20, "R3 fast pair+disp");
    send(4, 2000, 3000, 1000, 1, 0, 6, 1, 0, 6000, 21, "R3 slow pair+disp");
    send(4, 2000, 3000, 0, 0, 0, 8, 1, 0, 5000, 25, "R4 add m,imm even");
    idle(1);
    // odd-address penalty on wide bus
    send(4, 2000, 3000, 1001, 1, 0, 6, 1, 0, 6001, 25, "R6 odd one xfer");
    send(2, 0, 4000, 999, 1, 0, 7, 1, 0, 4999, 33, "R6 odd rmw");
    send(3, 16'hFFFF, 2, 0, 0, 0, 4, 1, 0, 1, 19, "R1 wrap odd R6");
    // narrow bus
    send(3, 2000, 4000, 0, 0, 0, 4, 1, 1, 6000, 19, "R7 narrow even");
    send(2, 0, 4000, 1000, 1, 0, 7, 1, 1, 5000, 33, "R7 narrow rmw");
    send(2, 0, 4000, 1000, 1, 0, 7, 0, 1, 5000, 25, "R8 byte narrow");
    send(2, 0, 4000, 999, 1, 0, 7, 0, 0, 4999, 25, "R8 byte odd wide");
    send(0, 0, 0, 0, 0, 0, 2, 1, 1, 0, 3, "R5 narrow reg");
    send(1, 1, 0, 0, 0, 0, 3, 1, 1, 1, 4, "R5 odd narrow reg");
    // displacement handling
    send(1, 16'h0010, 0, 16'h00F0, 1, 1, 4, 1, 0, 0, 17, "R1 disp8 sign");
    send(1, 16'h0100, 0, 16'h7777, 0, 0, 4, 1, 0, 16'h0100, 13, "R1 disp ignored");
    idle(2);
    #1;
    check(out_valid_o == 1'b0, "R10", "no output at end", out_valid_o, 0);
    check(sb.size() == 0, "R10", "scoreboard drained", sb.size(), 0);
    check(total_o == 32'(run_tot), "R9", "final total", total_o, run_tot);
    finish_run();
  end

endmodule